// File: doc/BRIEF.md
# Paired-Instruction Fetch Sequencer

This block sequences a small accumulator machine through a fixed cycle of fetch then execute. Each memory word carries two instructions side by side. A single memory fetch delivers both: the left one goes straight to the instruction register (opcode) and the address register (operand field). The right one is parked in an instruction buffer with a valid flag, so the following fetch takes it from the buffer without touching memory.

All memory traffic, for instruction fetches and for operands, goes through one address register (MAR) and one data register (MBR). The execute phase covers load, add and store on an accumulator, and an unconditional jump. A halt opcode, any unassigned opcode, or the halt input brings the sequencer to a stopped state that only reset leaves. The surrounding system supplies a synchronous memory with one cycle of read latency and pulses `start_i` once after reset.

Top module: `pairfetch_seq`

## Requirements
- R1: After reset PC, IR, MAR, MBR, IBR and the accumulator are zero, the buffer valid flag and `stopped_o` are low, and no memory access is issued until `start_i` is seen. Execution then begins at word address 0.
- R2: With the buffer empty, a fetch copies PC into MAR, reads that word into MBR, then loads IR from MBR[39:32], MAR from MBR[31:20], and IBR from MBR[19:0], and sets the valid flag. PC is unchanged. IR holds the left opcode four clock edges after the fetch cycle begins.
- R3: With the buffer valid, a fetch loads IR from IBR[19:12] and MAR from IBR[11:0], clears the valid flag, increments PC, and issues no memory read.
- R4: Every memory read or write uses MAR as its address and MBR as its write data. MAR does not change in the cycle after an access is issued. Read and write are never asserted together, and read data always lands in MBR.
- R5: Opcode 0x01 (load) sets the accumulator to the memory word at the operand address.
- R6: Opcode 0x02 (add) adds the memory word at the operand address to the accumulator, modulo 2^40.
- R7: Opcode 0x03 (store) writes the accumulator to memory at the operand address.
- R8: Opcode 0x04 (jump) sets PC to the operand address and discards the buffered instruction. The next fetch reads memory at the target, and a right-half instruction paired with a jump never executes.
- R9: Opcode 0x00 (halt) or any other opcode not listed stops the sequencer. `stopped_o` rises, no further memory access occurs, and `start_i` is ignored until reset.
- R10: `halt_i` high at a fetch boundary stops the sequencer before the next instruction, with the same stopped behaviour as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Leaves the idle state and begins fetching at address 0 |
| halt_i | input | 1 | Requests a stop at the next fetch boundary |
| mem_addr_o | output | 12 | Memory address, always MAR |
| mem_rd_o | output | 1 | Read request; data is due on the next cycle |
| mem_wr_o | output | 1 | Write request |
| mem_wdata_o | output | 40 | Write data, always MBR |
| mem_rdata_i | input | 40 | Read data, one cycle after the request |
| ir_o | output | 8 | Instruction register (opcode) |
| mar_o | output | 12 | Memory address register |
| mbr_o | output | 40 | Memory buffer register |
| ibr_o | output | 20 | Instruction buffer register (parked right-half instruction) |
| ibr_valid_o | output | 1 | IBR holds an instruction not yet executed |
| pc_o | output | 12 | Word address of the next memory fetch |
| acc_o | output | 40 | Accumulator |
| stopped_o | output | 1 | Sequencer has stopped and waits for reset |

## Verification
A memory fetch is due in stages. MAR takes PC one edge after the fetch starts, MBR holds the word three edges after it starts, and IR, MAR and IBR hold the split word on the fourth edge. A buffered fetch updates IR, MAR, PC and the valid flag on its single edge. A load or add changes the accumulator three edges after IR shows the opcode, and the next buffered instruction appears in IR one edge after that. The bench steps whole cycles from the start pulse and samples on falling edges exactly at those counts, and checks that the new value is not yet present one edge earlier. Whole-program results are read only once `stopped_o` is high, together with counts of memory reads and writes that show which fetches were served from the buffer.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

   localparam int OPC_HALT  = 0;
   localparam int OPC_LOAD  = 1;
   localparam int OPC_ADD   = 2;
   localparam int OPC_STORE = 3;
   localparam int OPC_JUMP  = 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_F_ADDR,
      ST_F_READ,
      ST_F_WAIT,
      ST_F_SPLIT,
      ST_EXEC,
      ST_X_WAIT,
      ST_X_ALU,
      ST_X_WR,
      ST_STOP
   } seq_state_e;

endpackage

// File: rtl/ifc_seq.sv
module ifc_seq
   import ifc_pkg::*;
#(
   parameter int OP_W = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            start_i,
   input  logic            halt_i,
   input  logic [OP_W-1:0] opcode_i,
   input  logic            ibr_valid_i,
   output logic            mar_from_pc_o,
   output logic            take_ibr_o,
   output logic            mbr_from_mem_o,
   output logic            split_o,
   output logic            mbr_from_acc_o,
   output logic            jump_o,
   output logic            acc_load_o,
   output logic            acc_add_o,
   output logic            mem_re_o,
   output logic            mem_we_o,
   output logic            stopped_o
);

   seq_state_e st_q, st_d;

   logic is_load, is_add, is_store, is_jump;
   assign is_load  = (opcode_i == OP_W'(OPC_LOAD));
   assign is_add   = (opcode_i == OP_W'(OPC_ADD));
   assign is_store = (opcode_i == OP_W'(OPC_STORE));
   assign is_jump  = (opcode_i == OP_W'(OPC_JUMP));

   always_comb begin
      st_d           = st_q;
      mar_from_pc_o  = 1'b0;
      take_ibr_o     = 1'b0;
      mbr_from_mem_o = 1'b0;
      split_o        = 1'b0;
      mbr_from_acc_o = 1'b0;
      jump_o         = 1'b0;
      acc_load_o     = 1'b0;
      acc_add_o      = 1'b0;
      mem_re_o       = 1'b0;
      mem_we_o       = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) st_d = ST_F_ADDR;
         end
         ST_F_ADDR: begin
            if (halt_i) begin
               st_d = ST_STOP;
            end else if (ibr_valid_i) begin
               take_ibr_o = 1'b1;
               st_d       = ST_EXEC;
            end else begin
               mar_from_pc_o = 1'b1;
               st_d          = ST_F_READ;
            end
         end
         ST_F_READ: begin
            mem_re_o = 1'b1;
            st_d     = ST_F_WAIT;
         end
         ST_F_WAIT: begin
            mbr_from_mem_o = 1'b1;
            st_d           = ST_F_SPLIT;
         end
         ST_F_SPLIT: begin
            split_o = 1'b1;
            st_d    = ST_EXEC;
         end
         ST_EXEC: begin
            if (is_load || is_add) begin
               mem_re_o = 1'b1;
               st_d     = ST_X_WAIT;
            end else if (is_store) begin
               mbr_from_acc_o = 1'b1;
               st_d           = ST_X_WR;
            end else if (is_jump) begin
               jump_o = 1'b1;
               st_d   = ST_F_ADDR;
            end else begin
               st_d = ST_STOP;
            end
         end
         ST_X_WAIT: begin
            mbr_from_mem_o = 1'b1;
            st_d           = ST_X_ALU;
         end
         ST_X_ALU: begin
            acc_load_o = is_load;
            acc_add_o  = !is_load;
            st_d       = ST_F_ADDR;
         end
         ST_X_WR: begin
            mem_we_o = 1'b1;
            st_d     = ST_F_ADDR;
         end
         default: st_d = ST_STOP;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= ST_IDLE;
      else         st_q <= st_d;
   end

   assign stopped_o = (st_q == ST_STOP);

   AST_RW_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(mem_re_o && mem_we_o)); // R4

   AST_STOP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_STOP) |=> (stopped_o && !mem_re_o && !mem_we_o)); // R9

   AST_HALT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_F_ADDR && halt_i) |=> stopped_o); // R10

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_IDLE) |-> (!mem_re_o && !mem_we_o)); // R1

endmodule

// File: rtl/ifc_acc_unit.sv
module ifc_acc_unit #(
   parameter int W        = 40,
   parameter bit SATURATE = 1'b0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic         add_i,
   input  logic [W-1:0] operand_i,
   output logic [W-1:0] acc_o
);

   logic [W-1:0] acc_q;
   logic [W-1:0] sum;

   generate
      if (SATURATE) begin : g_sat
         logic [W:0] wide;
         assign wide = {1'b0, acc_q} + {1'b0, operand_i};
         assign sum  = wide[W] ? {W{1'b1}} : wide[W-1:0];
      end else begin : g_wrap
         assign sum = acc_q + operand_i;

         AST_ADD_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            add_i |=> (acc_q == $past(acc_q) + $past(operand_i))); // R6
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     acc_q <= '0;
      else if (load_i) acc_q <= operand_i;
      else if (add_i)  acc_q <= sum;
   end

   assign acc_o = acc_q;

   AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (acc_q == $past(operand_i))); // R5

endmodule

// File: rtl/ifc_fetch_path.sv
module ifc_fetch_path #(
   parameter int OP_W   = 8,
   parameter int ADDR_W = 12
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        mar_from_pc_i,
   input  logic                        take_ibr_i,
   input  logic                        mbr_from_mem_i,
   input  logic                        split_i,
   input  logic                        mbr_from_acc_i,
   input  logic                        jump_i,
   input  logic                        mem_re_i,
   input  logic                        mem_we_i,
   input  logic [2*(OP_W+ADDR_W)-1:0]  mem_rdata_i,
   input  logic [2*(OP_W+ADDR_W)-1:0]  acc_i,
   output logic [OP_W-1:0]             ir_o,
   output logic [ADDR_W-1:0]           mar_o,
   output logic [2*(OP_W+ADDR_W)-1:0]  mbr_o,
   output logic [OP_W+ADDR_W-1:0]      ibr_o,
   output logic                        ibr_valid_o,
   output logic [ADDR_W-1:0]           pc_o
);

   localparam int INSTR_W = OP_W + ADDR_W;
   localparam int WORD_W  = 2 * INSTR_W;
   localparam int SLOTS   = 2;
   localparam int SLOT_LEFT  = SLOTS - 1;
   localparam int SLOT_RIGHT = 0;

   logic [OP_W-1:0]    ir_q;
   logic [ADDR_W-1:0]  mar_q, pc_q;
   logic [WORD_W-1:0]  mbr_q;
   logic [INSTR_W-1:0] ibr_q;
   logic               ibr_valid_q;

   logic [INSTR_W-1:0] slot_w [SLOTS];
   genvar s;
   generate
      for (s = 0; s < SLOTS; s++) begin : g_slot
         assign slot_w[s] = mbr_q[s*INSTR_W +: INSTR_W];
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ir_q        <= '0;
         mar_q       <= '0;
         pc_q        <= '0;
         mbr_q       <= '0;
         ibr_q       <= '0;
         ibr_valid_q <= 1'b0;
      end else begin
         if (mar_from_pc_i) mar_q <= pc_q;
         if (take_ibr_i) begin
            ir_q        <= ibr_q[INSTR_W-1 -: OP_W];
            mar_q       <= ibr_q[ADDR_W-1:0];
            ibr_valid_q <= 1'b0;
            pc_q        <= pc_q + ADDR_W'(1);
         end
         if (mbr_from_mem_i) mbr_q <= mem_rdata_i;
         if (mbr_from_acc_i) mbr_q <= acc_i;
         if (split_i) begin
            ir_q        <= slot_w[SLOT_LEFT][INSTR_W-1 -: OP_W];
            mar_q       <= slot_w[SLOT_LEFT][ADDR_W-1:0];
            ibr_q       <= slot_w[SLOT_RIGHT];
            ibr_valid_q <= 1'b1;
         end
         if (jump_i) begin
            pc_q        <= mar_q;
            ibr_valid_q <= 1'b0;
         end
      end
   end

   assign ir_o        = ir_q;
   assign mar_o       = mar_q;
   assign mbr_o       = mbr_q;
   assign ibr_o       = ibr_q;
   assign ibr_valid_o = ibr_valid_q;
   assign pc_o        = pc_q;

   AST_MAR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_re_i || mem_we_i) |=> $stable(mar_q)); // R4

   AST_WDATA_IS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_i |-> (mbr_q == acc_i)); // R7

   AST_SPLIT_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      split_i |=> (ibr_valid_q && ibr_q == $past(mbr_q[INSTR_W-1:0]) && $stable(pc_q))); // R2

   AST_BUF_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_ibr_i |=> (!ibr_valid_q && pc_q == $past(pc_q) + ADDR_W'(1)
                      && ir_q == $past(ibr_q[INSTR_W-1 -: OP_W]))); // R3

   AST_JUMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      jump_i |=> (pc_q == $past(mar_q) && !ibr_valid_q)); // R8

endmodule

// File: rtl/pairfetch_seq.sv
module pairfetch_seq #(
   parameter int OP_W         = 8,
   parameter int ADDR_W       = 12,
   parameter bit ADD_SATURATE = 1'b0
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        start_i,
   input  logic                        halt_i,
   output logic [ADDR_W-1:0]           mem_addr_o,
   output logic                        mem_rd_o,
   output logic                        mem_wr_o,
   output logic [2*(OP_W+ADDR_W)-1:0]  mem_wdata_o,
   input  logic [2*(OP_W+ADDR_W)-1:0]  mem_rdata_i,
   output logic [OP_W-1:0]             ir_o,
   output logic [ADDR_W-1:0]           mar_o,
   output logic [2*(OP_W+ADDR_W)-1:0]  mbr_o,
   output logic [OP_W+ADDR_W-1:0]      ibr_o,
   output logic                        ibr_valid_o,
   output logic [ADDR_W-1:0]           pc_o,
   output logic [2*(OP_W+ADDR_W)-1:0]  acc_o,
   output logic                        stopped_o
);

   localparam int INSTR_W = OP_W + ADDR_W;
   localparam int WORD_W  = 2 * INSTR_W;

   initial begin
      if (OP_W < 3)     $error("opcode field too narrow for the opcode set");
      if (ADDR_W < 1)   $error("address field must be at least one bit");
      if (WORD_W > 256) $error("word width beyond supported range");
   end

   logic mar_from_pc, take_ibr, mbr_from_mem, split, mbr_from_acc, jump;
   logic acc_load, acc_add, mem_re, mem_we;
   logic [WORD_W-1:0] acc, mbr;
   logic [OP_W-1:0]   ir;
   logic [ADDR_W-1:0] mar;
   logic              ibr_valid;

   ifc_seq #(.OP_W(OP_W)) seq_i (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .start_i        (start_i),
      .halt_i         (halt_i),
      .opcode_i       (ir),
      .ibr_valid_i    (ibr_valid),
      .mar_from_pc_o  (mar_from_pc),
      .take_ibr_o     (take_ibr),
      .mbr_from_mem_o (mbr_from_mem),
      .split_o        (split),
      .mbr_from_acc_o (mbr_from_acc),
      .jump_o         (jump),
      .acc_load_o     (acc_load),
      .acc_add_o      (acc_add),
      .mem_re_o       (mem_re),
      .mem_we_o       (mem_we),
      .stopped_o      (stopped_o)
   );

   ifc_fetch_path #(.OP_W(OP_W), .ADDR_W(ADDR_W)) path_i (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .mar_from_pc_i  (mar_from_pc),
      .take_ibr_i     (take_ibr),
      .mbr_from_mem_i (mbr_from_mem),
      .split_i        (split),
      .mbr_from_acc_i (mbr_from_acc),
      .jump_i         (jump),
      .mem_re_i       (mem_re),
      .mem_we_i       (mem_we),
      .mem_rdata_i    (mem_rdata_i),
      .acc_i          (acc),
      .ir_o           (ir),
      .mar_o          (mar),
      .mbr_o          (mbr),
      .ibr_o          (ibr_o),
      .ibr_valid_o    (ibr_valid),
      .pc_o           (pc_o)
   );

   ifc_acc_unit #(.W(WORD_W), .SATURATE(ADD_SATURATE)) acc_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (acc_load),
      .add_i     (acc_add),
      .operand_i (mbr),
      .acc_o     (acc)
   );

   assign mem_addr_o  = mar;
   assign mem_wdata_o = mbr;
   assign mem_rd_o    = mem_re;
   assign mem_wr_o    = mem_we;
   assign ir_o        = ir;
   assign mar_o       = mar;
   assign mbr_o       = mbr;
   assign ibr_valid_o = ibr_valid;
   assign acc_o       = acc;

   AST_READ_LANDS_IN_MBR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_rd_o |=> ##1 (mbr == $past(mem_rdata_i))); // R4

endmodule

// File: tb/pairfetch_seq_tb_top.sv
`timescale 1ns/1ps
module pairfetch_seq_tb_top;

   localparam int OP_W = 8, ADDR_W = 12, INSTR_W = 20, WORD_W = 40, DEPTH = 64;
   localparam int LD = 1, AD = 2, ST = 3, JP = 4, HL = 0;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, halt = 1'b0;
   logic [ADDR_W-1:0]  mem_addr, mar, pc;
   logic               mem_rd, mem_wr, ibr_valid, stopped;
   logic [WORD_W-1:0]  mem_wdata, mem_rdata, mbr, acc;
   logic [OP_W-1:0]    ir;
   logic [INSTR_W-1:0] ibr;

   always #2 clk = ~clk;

   pairfetch_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .halt_i(halt),
      .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
      .ir_o(ir), .mar_o(mar), .mbr_o(mbr), .ibr_o(ibr), .ibr_valid_o(ibr_valid),
      .pc_o(pc), .acc_o(acc), .stopped_o(stopped)
   );

   logic [WORD_W-1:0] mem [DEPTH];
   logic              pk_en = 1'b0;
   logic [5:0]        pk_a = '0;
   logic [WORD_W-1:0] pk_d = '0;
   int rd_cnt, wr_cnt, checks = 0, errors = 0;

   always @(posedge clk) begin
      if (pk_en) mem[pk_a] <= pk_d;
      else if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
   end

   always @(posedge clk) begin
      if (!rst_n) begin rd_cnt <= 0; wr_cnt <= 0; end
      else begin
         if (mem_rd) rd_cnt <= rd_cnt + 1;
         if (mem_wr) wr_cnt <= wr_cnt + 1;
      end
   end

   function automatic logic [INSTR_W-1:0] ins(input int op, input int a);
      return {8'(op), 12'(a)};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic poke(input int a, input logic [WORD_W-1:0] d);
      @(negedge clk); pk_en = 1'b1; pk_a = 6'(a); pk_d = d;
      @(negedge clk); pk_en = 1'b0;
   endtask

   task automatic reset_clear();
      @(negedge clk); rst_n = 1'b0; start = 1'b0; halt = 1'b0;
      for (int i = 0; i < DEPTH; i++) poke(i, '0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic go();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_stopped(input string req);
      for (int i = 0; i < 600 && !stopped; i++) @(negedge clk);
      chk(stopped, req, 64'(stopped), 64'd1);
   endtask

   // operand x, operand y, expected (x+y) mod 2^40
   localparam logic [3*WORD_W-1:0] VEC [5] = '{
      {40'd5,             40'd7,             40'd12},
      {40'd0,             40'd0,             40'd0},
      {40'hFF_FFFF_FFFF,  40'd1,             40'd0},
      {40'h12_3456_789A,  40'h01_0101_0101,  40'h13_3557_799B},
      {40'h80_0000_0000,  40'h80_0000_0001,  40'h00_0000_0001}
   };

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [WORD_W-1:0] x, y, e, a0;
      int r0, w0;

      // R1: reset state and idle without start
      reset_clear();
      chk(pc == 0 && ir == 0 && mar == 0, "R1 pc/ir/mar zero", {pc, ir, mar}, 0);
      chk(mbr == 0 && ibr == 0 && acc == 0, "R1 mbr/ibr/acc zero", mbr | 64'(ibr) | acc, 0);
      chk(!ibr_valid && !stopped, "R1 flags low", {ibr_valid, stopped}, 0);
      repeat (10) @(negedge clk);
      chk(rd_cnt == 0 && wr_cnt == 0, "R1 no access before start", rd_cnt + wr_cnt, 0);

      // table: load x, add y, store, halt from buffer
      for (int v = 0; v < 5; v++) begin
         {x, y, e} = VEC[v];
         reset_clear();
         poke(0, {ins(LD, 10), ins(AD, 11)});
         poke(1, {ins(ST, 12), ins(HL, 0)});
         poke(10, x); poke(11, y);
         go();
         wait_stopped("R9 halt opcode stops");
         chk(acc == e, "R6 add modulo 2^40", acc, e);
         chk(mem[12] == e, "R7 store writes acc", mem[12], e);
         chk(pc == 2, "R3 pc after two words", pc, 2);
         chk(rd_cnt == 4, "R3 buffered fetches skip memory", rd_cnt, 4);
         chk(wr_cnt == 1, "R7 single write", wr_cnt, 1);
      end

      // R2/R3/R5 stage timing from the start pulse
      reset_clear();
      poke(0, {ins(LD, 10), ins(AD, 11)});
      poke(1, {ins(ST, 12), ins(HL, 0)});
      poke(10, 40'd5); poke(11, 40'd7);
      go();
      repeat (3) @(negedge clk);
      chk(ir == 0 && !ibr_valid, "R2 split not yet due", ir, 0);
      chk(mbr == {ins(LD, 10), ins(AD, 11)}, "R4 word lands in MBR", mbr, {ins(LD, 10), ins(AD, 11)});
      @(negedge clk);
      chk(ir == LD && mar == 10, "R2 left half to IR/MAR", {ir, mar}, {8'(LD), 12'd10});
      chk(ibr == ins(AD, 11) && ibr_valid, "R2 right half parked", ibr, ins(AD, 11));
      chk(pc == 0, "R2 pc unchanged", pc, 0);
      repeat (3) @(negedge clk);
      chk(acc == 5, "R5 load result", acc, 5);
      chk(ir == LD, "R3 buffered fetch not yet due", ir, LD);
      @(negedge clk);
      chk(ir == AD && mar == 11 && pc == 1 && !ibr_valid, "R3 buffered fetch", {ir, mar, pc}, {8'(AD), 12'd11, 12'd1});
      chk(rd_cnt == 2, "R3 no read for buffered fetch", rd_cnt, 2);
      wait_stopped("R9 stop after timing run");

      // R8: jump discards partner, fetches at target
      reset_clear();
      poke(0, {ins(JP, 5), ins(LD, 10)});
      poke(5, {ins(LD, 11), ins(HL, 0)});
      poke(10, 40'd99); poke(11, 40'd7);
      go();
      wait_stopped("R8 jump program stops");
      chk(acc == 7, "R8 right half of jump word skipped", acc, 7);
      chk(pc == 6, "R8 pc from target", pc, 6);
      chk(rd_cnt == 3, "R8 target word fetched from memory", rd_cnt, 3);

      // R9: unassigned opcode stops; start then ignored
      reset_clear();
      poke(0, {ins(8'h7E, 10), ins(LD, 10)});
      poke(10, 40'd55);
      go();
      wait_stopped("R9 unknown opcode stops");
      chk(acc == 0 && rd_cnt == 1, "R9 nothing executed after stop", acc + 64'(rd_cnt), 1);
      go();
      repeat (20) @(negedge clk);
      chk(stopped && rd_cnt == 1 && wr_cnt == 0 && acc == 0, "R9 start ignored after stop", rd_cnt, 1);

      // R10: halt input ends an endless loop
      reset_clear();
      poke(0, {ins(AD, 20), ins(JP, 0)});
      poke(20, 40'd3);
      go();
      repeat (60) @(negedge clk);
      halt = 1'b1;
      wait_stopped("R10 halt input stops");
      halt = 1'b0;
      chk(acc != 0 && (acc % 3) == 0, "R10 whole adds only", acc, 3);
      r0 = rd_cnt; w0 = wr_cnt; a0 = acc;
      repeat (20) @(negedge clk);
      chk(rd_cnt == r0 && wr_cnt == w0 && acc == a0, "R10 quiet after halt", rd_cnt, r0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule